// File: doc/BRIEF.md
# Dual stereo serial audio port

This block is the serial audio edge of a sound processing core. From the system clock it derives a bit clock and a word-select (frame) signal. It drives two serial output lines, each carrying a left and a right word, which gives four playback channels. It receives one serial input line carrying a stereo pair. Each frame lasts a fixed 1024 system clocks and is split into 64 bit slots of 16 clocks each. Every output word is 32 slots long.

The core supplies four 20-bit playback samples and two 12-bit auxiliary control fields. The block raises a one-cycle load strobe in the last cycle of every frame, and it captures those inputs at the clock edge that ends that cycle. The output sample resolution can be 16, 18 or 20 bits. Bit positions below the chosen resolution are sent as zero. The low 12 slots of each word on the first line carry the auxiliary field; on the second line they are zero. The word-select timing can be switched at run time between an I2S-style layout and a left-justified layout. A new setting takes effect at the next frame boundary.

The input line carries 16-bit samples. The two words captured during a frame are presented together with a one-cycle receive strobe in the first cycle of the following frame.

Top module: `serial_audio_port`

## Requirements
- R1: `bclk` has a period of 16 clocks. It is low while the in-frame count modulo 16 is 0..7 and high for 8..15, which gives 64 bit clocks per frame.
- R2: A frame lasts 1024 clocks. `load_stb` is high only in the last cycle of a frame (count 1023). `tx_l0`, `tx_r0`, `tx_l1`, `tx_r1`, `aux_l`, `aux_r`, `fmt_lj` and `res_sel` are captured at the edge that ends that cycle, and changes at any other time have no effect on the outputs.
- R3: `wsel` is low during slots 0..31 (left word) and high during slots 32..63 (right word), in both formats.
- R4: With `fmt_lj`=1 (left-justified), slot k of a word (k=0..31) carries bit 31-k of the 32-bit word W = {masked sample[19:0], low field[11:0]}, so the sample MSB is in slot 0.
- R5: With `fmt_lj`=0 (I2S), each line is delayed by one slot relative to R4. Slot 0 of a frame carries the last bit of the previous frame's right word, and the sample MSB falls one bit clock after `wsel` changes.
- R6: `res_sel` selects the resolution: 0 keeps sample bits [19:4], 1 keeps [19:2], 2 or 3 keeps [19:0]. Dropped bits are transmitted as zero.
- R7: On line 0 (`sdo[0]`) the low field of the left word is `aux_l` and of the right word is `aux_r`, sent with bit 11 first. On line 1 the low field is zero.
- R8: `sdi` is sampled at the rising edge of `bclk`. The 16-bit word is read MSB first from slots 0..15 / 32..47 when the frame's format is left-justified, and from slots 1..16 / 33..48 when it is I2S. All other slots are ignored.
- R9: `rx_stb` is high for exactly one cycle, the first cycle of the next frame. At that point `rx_l` and `rx_r` show the words captured in the frame that just ended, and they hold their values until the next strobe.
- R10: While reset is asserted, all outputs are zero. The first frame after reset uses the I2S format and transmits zeros.
- R11: `sdo` and `wsel` change only in the cycle in which `bclk` falls (count modulo 16 = 0), never while `bclk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_lj | input | 1 | 1 = left-justified, 0 = I2S; captured at frame end |
| res_sel | input | 2 | Output resolution code; captured at frame end |
| tx_l0 | input | 20 | Line 0 left sample |
| tx_r0 | input | 20 | Line 0 right sample |
| tx_l1 | input | 20 | Line 1 left sample |
| tx_r1 | input | 20 | Line 1 right sample |
| aux_l | input | 12 | Control bits in the left word of line 0 |
| aux_r | input | 12 | Control bits in the right word of line 0 |
| sdi | input | 1 | Serial input data |
| bclk | output | 1 | Bit clock |
| wsel | output | 1 | Word select (low = left) |
| sdo | output | 2 | Serial output lines 0 and 1 |
| load_stb | output | 1 | One-cycle strobe: transmit inputs captured at its end |
| rx_stb | output | 1 | One-cycle strobe: received pair is valid |
| rx_l | output | 16 | Received left word |
| rx_r | output | 16 | Received right word |

## Verification
The last cycle of a frame is both a slot boundary and the moment the shift register is reloaded. In I2S mode the one-slot delay stage must keep the outgoing final bit of the right word while fresh words replace the shifter contents. The same edge also moves the received pair to the outputs and latches a possibly changed format. The bench provokes this by sending words whose final bit is set and by flipping format and resolution on alternating frames. It judges the result by comparing every slot of the following frame, slot 0 in particular, with a behavioural frame model. Some frames also change the inputs in mid-frame, and the expected outputs are built only from the values present at the strobe.

// File: rtl/sap_pkg.sv
package sap_pkg;

    // Word-select layout chosen for a frame
    typedef enum logic {
        FMT_I2S = 1'b0,
        FMT_LJ  = 1'b1
    } sap_fmt_e;

    // Output resolution codes
    typedef enum logic [1:0] {
        RES_NARROW = 2'd0,
        RES_MID    = 2'd1,
        RES_FULL   = 2'd2,
        RES_FULL_B = 2'd3
    } sap_res_e;

    // Number of sample bits kept for a resolution code, given the full width
    function automatic int unsigned sap_keep_bits(input logic [1:0] code,
                                                  input int unsigned full);
        case (sap_res_e'(code))
            RES_NARROW: return full - 4;
            RES_MID:    return full - 2;
            default:    return full;
        endcase
    endfunction

endpackage

// File: rtl/sap_timebase.sv
module sap_timebase #(
    parameter int unsigned SLOT_CLKS = 16,
    parameter int unsigned SLOTS     = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    output logic                     bclk_o,
    output logic                     wsel_o,
    output logic [$clog2(SLOTS)-1:0] slot_o,
    output logic                     slot_last_o,
    output logic                     frame_last_o,
    output logic                     capture_o
);
    localparam int unsigned FRAME_CLKS = SLOT_CLKS * SLOTS;
    localparam int unsigned CW         = $clog2(FRAME_CLKS);
    localparam int unsigned PW         = $clog2(SLOT_CLKS);
    localparam int unsigned HALF_SLOT  = SLOT_CLKS / 2;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // bit clock low in the first half of a slot, high in the second
    assign bclk_o       = st_q.cnt[PW-1];
    assign wsel_o       = st_q.cnt[CW-1];
    assign slot_o       = st_q.cnt[CW-1:PW];
    assign slot_last_o  = &st_q.cnt[PW-1:0];
    assign frame_last_o = &st_q.cnt;
    // the edge that ends this cycle raises the bit clock
    assign capture_o    = (st_q.cnt[PW-1:0] == PW'(HALF_SLOT - 1));

endmodule

// File: rtl/sap_tx_lane.sv
module sap_tx_lane
    import sap_pkg::*;
#(
    parameter int unsigned OUT_BITS = 20,
    parameter int unsigned AUX_BITS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                shift_i,
    input  logic                lj_i,
    input  logic [1:0]          res_i,
    input  logic [OUT_BITS-1:0] left_i,
    input  logic [OUT_BITS-1:0] right_i,
    input  logic [AUX_BITS-1:0] aux_l_i,
    input  logic [AUX_BITS-1:0] aux_r_i,
    output logic                sdo_o
);
    localparam int unsigned WORD_BITS = OUT_BITS + AUX_BITS;
    localparam int unsigned SR_BITS   = 2 * WORD_BITS;

    typedef struct packed {
        logic [SR_BITS-1:0] sr;
        logic               dly;
    } lane_state_t;

    lane_state_t          st_d, st_q;
    int unsigned          keep;
    logic [OUT_BITS-1:0]  mask;
    logic [WORD_BITS-1:0] word_l, word_r;

    always_comb begin
        keep = sap_keep_bits(res_i, OUT_BITS);
        for (int i = 0; i < OUT_BITS; i++) begin
            mask[i] = (i >= int'(OUT_BITS - keep));
        end
        word_l = {left_i & mask, aux_l_i};
        word_r = {right_i & mask, aux_r_i};
    end

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            // the frame end is also a slot end: keep the departing bit
            st_d.dly = st_q.sr[SR_BITS-1];
            st_d.sr  = {word_l, word_r};
        end else if (shift_i) begin
            st_d.dly = st_q.sr[SR_BITS-1];
            st_d.sr  = {st_q.sr[SR_BITS-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo_o = lj_i ? st_q.sr[SR_BITS-1] : st_q.dly;

endmodule

// File: rtl/sap_rx.sv
module sap_rx #(
    parameter int unsigned SLOTS   = 64,
    parameter int unsigned IN_BITS = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     capture_i,
    input  logic                     frame_last_i,
    input  logic [$clog2(SLOTS)-1:0] slot_i,
    input  logic                     lj_i,
    input  logic                     sdi_i,
    output logic                     stb_o,
    output logic [IN_BITS-1:0]       left_o,
    output logic [IN_BITS-1:0]       right_o
);
    localparam int unsigned SW = $clog2(SLOTS);

    typedef struct packed {
        logic [IN_BITS-1:0] sh_l;
        logic [IN_BITS-1:0] sh_r;
        logic [IN_BITS-1:0] out_l;
        logic [IN_BITS-1:0] out_r;
        logic               stb;
    } rx_state_t;

    rx_state_t   st_d, st_q;
    int unsigned pos;
    int unsigned first;
    logic        in_win;
    logic        is_right;

    always_comb begin
        pos      = 32'(slot_i[SW-2:0]);
        is_right = slot_i[SW-1];
        first    = lj_i ? 0 : 1;
        in_win   = (pos >= first) && (pos < first + IN_BITS);

        st_d     = st_q;
        st_d.stb = 1'b0;
        if (capture_i && in_win) begin
            if (is_right) st_d.sh_r = {st_q.sh_r[IN_BITS-2:0], sdi_i};
            else          st_d.sh_l = {st_q.sh_l[IN_BITS-2:0], sdi_i};
        end
        if (frame_last_i) begin
            st_d.out_l = st_q.sh_l;
            st_d.out_r = st_q.sh_r;
            st_d.stb   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stb_o   = st_q.stb;
    assign left_o  = st_q.out_l;
    assign right_o = st_q.out_r;

endmodule

// File: rtl/serial_audio_port.sv
module serial_audio_port
    import sap_pkg::*;
#(
    parameter int unsigned SLOT_CLKS = 16,
    parameter int unsigned OUT_BITS  = 20,
    parameter int unsigned AUX_BITS  = 12,
    parameter int unsigned IN_BITS   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fmt_lj,
    input  logic [1:0]          res_sel,
    input  logic [OUT_BITS-1:0] tx_l0,
    input  logic [OUT_BITS-1:0] tx_r0,
    input  logic [OUT_BITS-1:0] tx_l1,
    input  logic [OUT_BITS-1:0] tx_r1,
    input  logic [AUX_BITS-1:0] aux_l,
    input  logic [AUX_BITS-1:0] aux_r,
    input  logic                sdi,
    output logic                bclk,
    output logic                wsel,
    output logic [1:0]          sdo,
    output logic                load_stb,
    output logic                rx_stb,
    output logic [IN_BITS-1:0]  rx_l,
    output logic [IN_BITS-1:0]  rx_r
);
    localparam int unsigned LINES     = 2;
    localparam int unsigned WORD_BITS = OUT_BITS + AUX_BITS;
    localparam int unsigned SLOTS     = 2 * WORD_BITS;
    localparam int unsigned SW        = $clog2(SLOTS);

    typedef struct packed {
        sap_fmt_e fmt;
    } top_state_t;

    top_state_t          st_d, st_q;
    logic [SW-1:0]       slot;
    logic                slot_last;
    logic                frame_last;
    logic                capture;
    logic                lj;
    logic [OUT_BITS-1:0] smp_l [LINES];
    logic [OUT_BITS-1:0] smp_r [LINES];

    sap_timebase #(
        .SLOT_CLKS (SLOT_CLKS),
        .SLOTS     (SLOTS)
    ) i_timebase (
        .clk          (clk),
        .rst_n        (rst_n),
        .bclk_o       (bclk),
        .wsel_o       (wsel),
        .slot_o       (slot),
        .slot_last_o  (slot_last),
        .frame_last_o (frame_last),
        .capture_o    (capture)
    );

    // format follows the frame boundary, together with the samples
    always_comb begin
        st_d = st_q;
        if (frame_last) st_d.fmt = sap_fmt_e'(fmt_lj);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{fmt: FMT_I2S};
        else        st_q <= st_d;
    end

    assign lj       = (st_q.fmt == FMT_LJ);
    assign load_stb = frame_last;

    assign smp_l[0] = tx_l0;
    assign smp_r[0] = tx_r0;
    assign smp_l[1] = tx_l1;
    assign smp_r[1] = tx_r1;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [AUX_BITS-1:0] low_l, low_r;
        if (g == 0) begin : g_aux
            assign low_l = aux_l;
            assign low_r = aux_r;
        end else begin : g_plain
            assign low_l = '0;
            assign low_r = '0;
        end

        sap_tx_lane #(
            .OUT_BITS (OUT_BITS),
            .AUX_BITS (AUX_BITS)
        ) i_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (frame_last),
            .shift_i (slot_last),
            .lj_i    (lj),
            .res_i   (res_sel),
            .left_i  (smp_l[g]),
            .right_i (smp_r[g]),
            .aux_l_i (low_l),
            .aux_r_i (low_r),
            .sdo_o   (sdo[g])
        );
    end

    sap_rx #(
        .SLOTS   (SLOTS),
        .IN_BITS (IN_BITS)
    ) i_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .capture_i    (capture),
        .frame_last_i (frame_last),
        .slot_i       (slot),
        .lj_i         (lj),
        .sdi_i        (sdi),
        .stb_o        (rx_stb),
        .left_o       (rx_l),
        .right_o      (rx_r)
    );

endmodule

// File: rtl/sap_checker.sv
module sap_checker #(
    parameter int unsigned SLOT_CLKS = 16,
    parameter int unsigned WORD_BITS = 32
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bclk,
    input logic       wsel,
    input logic [1:0] sdo,
    input logic       load_stb,
    input logic       rx_stb
);
    localparam int unsigned FRAME_CLKS = SLOT_CLKS * 2 * WORD_BITS;

    logic        bclk_p;
    logic        bclk_seen;
    logic [31:0] bclk_gap;
    logic        frame_seen;
    logic [31:0] frame_gap;
    logic        bclk_rise;

    assign bclk_rise = bclk && !bclk_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_p     <= 1'b0;
            bclk_seen  <= 1'b0;
            bclk_gap   <= '0;
            frame_seen <= 1'b0;
            frame_gap  <= '0;
        end else begin
            bclk_p <= bclk;
            if (bclk_rise) begin
                bclk_seen <= 1'b1;
                bclk_gap  <= 32'd1;
            end else begin
                bclk_gap <= bclk_gap + 32'd1;
            end
            if (load_stb) begin
                frame_seen <= 1'b1;
                frame_gap  <= 32'd1;
            end else begin
                frame_gap <= frame_gap + 32'd1;
            end
        end
    end

    AST_BCLK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_rise && bclk_seen) |-> (bclk_gap == SLOT_CLKS)); // R1

    AST_FRAME_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && frame_seen) |-> (frame_gap == FRAME_CLKS)); // R2

    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> !load_stb); // R2

    AST_WS_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> (wsel && bclk)); // R3

    AST_RX_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> rx_stb); // R9

    AST_RX_ONLY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stb |-> $past(load_stb)); // R9

    AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(bclk) |-> ($stable(sdo) && $stable(wsel))); // R11

endmodule

bind serial_audio_port sap_checker #(
    .SLOT_CLKS (SLOT_CLKS),
    .WORD_BITS (OUT_BITS + AUX_BITS)
) i_sap_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bclk     (bclk),
    .wsel     (wsel),
    .sdo      (sdo),
    .load_stb (load_stb),
    .rx_stb   (rx_stb)
);

// File: tb/test_serial_audio_port.sv
module test_serial_audio_port;

    localparam int FRAMES = 14;
    localparam int FCLK   = 1024;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fmt_lj;
    logic [1:0]  res_sel;
    logic [19:0] tx_l0, tx_r0, tx_l1, tx_r1;
    logic [11:0] aux_l, aux_r;
    logic        sdi;
    logic        bclk, wsel, load_stb, rx_stb;
    logic [1:0]  sdo;
    logic [15:0] rx_l, rx_r;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    serial_audio_port i_serial_audio_port (
        .clk(clk), .rst_n(rst_n), .fmt_lj(fmt_lj), .res_sel(res_sel),
        .tx_l0(tx_l0), .tx_r0(tx_r0), .tx_l1(tx_l1), .tx_r1(tx_r1),
        .aux_l(aux_l), .aux_r(aux_r), .sdi(sdi),
        .bclk(bclk), .wsel(wsel), .sdo(sdo), .load_stb(load_stb),
        .rx_stb(rx_stb), .rx_l(rx_l), .rx_r(rx_r)
    );

    // behavioural frame model: one bit and one requirement code per slot
    bit          cur_bits  [2][64];
    bit          prev_bits [2][64];
    int          cur_tag   [2][64];
    int          prev_tag  [2][64];
    bit          cur_lj = 1'b0;
    logic [15:0] rx_sent_l = '0, rx_sent_r = '0;
    logic [15:0] rx_exp_l  = '0, rx_exp_r  = '0;
    logic [1:0]  last_sdo  = '0;

    function automatic string tag_name(input int c);
        case (c)
            2:       return "R2";
            5:       return "R5";
            6:       return "R6";
            7:       return "R7";
            10:      return "R10";
            default: return "R4";
        endcase
    endfunction

    function automatic int mix(input int x);
        int y;
        y = x * 1103515245 + 12345;
        return y ^ (y >>> 13);
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic set_inputs(input int f, input bit junk);
        int sd;
        sd      = junk ? f * 7919 + 3 : f * 104729 + 11;
        fmt_lj  = junk ? ~f[0] : f[0];
        res_sel = junk ? 2'(f + 1) : 2'(f / 2);
        if (f == 3 && !junk) begin
            tx_l0 = '1; tx_r0 = '1; tx_l1 = '1; tx_r1 = '1;
            aux_l = '1; aux_r = '1;
        end else if (f == 4 && !junk) begin
            tx_l0 = '0; tx_r0 = '0; tx_l1 = '0; tx_r1 = '0;
            aux_l = '0; aux_r = 12'h001;
        end else begin
            tx_l0 = 20'(mix(sd));     tx_r0 = 20'(mix(sd + 1));
            tx_l1 = 20'(mix(sd + 2)); tx_r1 = 20'(mix(sd + 3));
            aux_l = 12'(mix(sd + 4)); aux_r = 12'(mix(sd + 5)) | 12'h001;
        end
    endtask

    // builds the expected serial frame from the inputs present at the strobe
    task automatic build_frame(input bit glitch);
        for (int l = 0; l < 2; l++) begin
            for (int s = 0; s < 64; s++) begin
                int          w, b, keep, sb;
                logic [19:0] smp;
                logic [11:0] ax;
                w = s / 32;
                b = 31 - (s % 32);
                if (l == 0) begin
                    smp = (w == 0) ? tx_l0 : tx_r0;
                    ax  = (w == 0) ? aux_l : aux_r;
                end else begin
                    smp = (w == 0) ? tx_l1 : tx_r1;
                    ax  = '0;
                end
                keep = (res_sel == 2'd0) ? 16 : (res_sel == 2'd1) ? 18 : 20;
                if (b < 12) begin
                    cur_bits[l][s] = ax[b];            // R7 low field
                    cur_tag[l][s]  = 7;
                end else begin
                    sb = b - 12;
                    if (sb < 20 - keep) begin
                        cur_bits[l][s] = 1'b0;         // R6 dropped bits
                        cur_tag[l][s]  = 6;
                    end else begin
                        cur_bits[l][s] = smp[sb];
                        cur_tag[l][s]  = fmt_lj ? 4 : 5;
                    end
                end
                if (glitch) cur_tag[l][s] = 2;
            end
        end
    endtask

    initial begin
        int fr;
        rst_n   = 1'b0;
        fmt_lj  = 1'b0;
        res_sel = 2'd2;
        tx_l0 = '0; tx_r0 = '0; tx_l1 = '0; tx_r1 = '0;
        aux_l = '0; aux_r = '0;
        sdi   = 1'b0;
        for (int l = 0; l < 2; l++)
            for (int s = 0; s < 64; s++) begin
                cur_bits[l][s] = 1'b0; prev_bits[l][s] = 1'b0;
                cur_tag[l][s] = 10;    prev_tag[l][s] = 10;
            end

        // R10: outputs idle while reset is held
        repeat (4) begin
            @(negedge clk);
            chk("R10", "bclk in reset", 32'(bclk), 32'd0);
            chk("R10", "wsel in reset", 32'(wsel), 32'd0);
            chk("R10", "sdo in reset", 32'(sdo), 32'd0);
            chk("R10", "strobes in reset", 32'({load_stb, rx_stb}), 32'd0);
            chk("R10", "rx words in reset", {rx_l, rx_r}, 32'd0);
        end
        rst_n = 1'b1;

        fr = 0;
        for (int t = 0; t < FRAMES * FCLK; t++) begin
            int tf, s, ph;
            tf = t % FCLK;
            s  = tf / 16;
            ph = tf % 16;

            chk("R1", "bclk", 32'(bclk), 32'(ph >= 8));
            chk("R3", "wsel", 32'(wsel), 32'(s >= 32));
            chk("R2", "load_stb", 32'(load_stb), 32'(tf == FCLK - 1));
            for (int l = 0; l < 2; l++) begin
                bit e;
                int c;
                if (cur_lj) begin
                    e = cur_bits[l][s];
                    c = cur_tag[l][s];
                end else if (s == 0) begin
                    e = prev_bits[l][63];              // R5 carried bit
                    c = (prev_tag[l][63] == 10) ? 10 : 5;
                end else begin
                    e = cur_bits[l][s - 1];
                    c = cur_tag[l][s - 1];
                end
                chk(tag_name(c), l == 0 ? "sdo[0]" : "sdo[1]", 32'(sdo[l]), 32'(e));
            end
            if (ph != 0 && t != 0)
                chk("R11", "sdo held off falling edge", 32'(sdo), 32'(last_sdo));
            last_sdo = sdo;
            chk("R9", "rx_stb", 32'(rx_stb), 32'(tf == 0 && t > 0));
            chk("R8", "rx_l", 32'(rx_l), 32'(rx_exp_l));
            chk("R8", "rx_r", 32'(rx_r), 32'(rx_exp_r));

            // stimulus; inputs never change in the strobe cycle
            if (tf == 5) set_inputs(fr, (fr % 3) == 2);
            if (tf == 500 && (fr % 3) == 2) set_inputs(fr, 1'b0);

            if (tf == FCLK - 1) begin
                prev_bits = cur_bits;
                prev_tag  = cur_tag;
                cur_lj    = fmt_lj;
                build_frame((fr % 3) == 2);
                rx_exp_l  = rx_sent_l;
                rx_exp_r  = rx_sent_r;
                if (fr + 1 == 3) begin
                    rx_sent_l = 16'hFFFF; rx_sent_r = 16'hFFFF;
                end else if (fr + 1 == 5) begin
                    rx_sent_l = 16'h8001; rx_sent_r = 16'h0001;
                end else begin
                    rx_sent_l = 16'(mix(fr * 31 + 5));
                    rx_sent_r = 16'(mix(fr * 31 + 6));
                end
                fr++;
            end

            // R8: serial input word placement for the current frame's format
            begin
                int k, off, w;
                w   = s / 32;
                k   = s % 32;
                off = cur_lj ? 0 : 1;
                if (k >= off && k - off < 16)
                    sdi = (w == 0) ? rx_sent_l[15 - (k - off)] : rx_sent_r[15 - (k - off)];
                else
                    sdi = 1'b1 ^ 1'b1;
            end
            @(negedge clk);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog: actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule